// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block steers data between a 32-bit register file and a 32-bit external data bus. On the load side it takes the raw bus word, the two low address bits, an access-size flag and an endianness select, and it returns the value to be written into the destination register. Byte loads pick out one lane and zero-fill the rest. Word loads from a non-word-aligned address are neither faulted nor split into two accesses: the bus word is rotated in a single pass.

On the store side it takes the register value and produces the bus write word together with four per-lane write enables. Byte stores copy the low byte onto every lane and enable only the addressed lane. Word stores pass the register through unchanged.

The endianness select is read anew on every access. A parameter chooses between purely combinational outputs and a single output register stage.

Top module: `lane_align_unit`

## Requirements
- R1: With bigEndian=1 and accByte=1, an address offset of 0, 1, 2 or 3 selects bus bits 31:24, 23:16, 15:8 or 7:0 respectively.
- R2: With bigEndian=0 and accByte=1, an address offset k selects bus bits 8k+7:8k.
- R3: For a byte load, the selected byte appears in loadResult[7:0] and loadResult[31:8] is zero.
- R4: With bigEndian=1 and accByte=0, offset 0 returns the bus word unchanged and offset 2 returns it rotated by 16 bits, so the addressed byte sits in bits 31:24.
- R5: With bigEndian=1 and accByte=0, offset 1 returns the bus word rotated right by 8 and offset 3 returns it rotated left by 8, so the addressed byte sits in bits 15:8.
- R6: With bigEndian=0 and accByte=0, offset k returns the bus word rotated right by 8k bits, so the addressed byte sits in bits 7:0.
- R7: For a byte store (accByte=1), every byte lane of busWdata equals regWdata[7:0].
- R8: For a word store (accByte=0), busWdata equals regWdata bit for bit, whatever the offset.
- R9: byteEn bit i enables lane i (bits 8i+7:8i). When storeEn=1 and accByte=1, only lane k is enabled under little-endian and only lane 3-k under big-endian. When storeEn=1 and accByte=0, all four lanes are enabled. When storeEn=0, byteEn is 0.
- R10: The outputs depend only on the inputs of the current access, so a change of endianness takes effect on the very next access. With REG_OUT=1 the outputs follow the inputs one clock later and are zero while rstN is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset |
| accByte | input | 1 | 1 = byte access, 0 = word access |
| addrLo | input | 2 | Low address bits (offset within the word) |
| bigEndian | input | 1 | 1 = big-endian lane order, 0 = little-endian |
| storeEn | input | 1 | Store in progress; gates the lane enables |
| busRdata | input | 32 | Raw word read from the bus |
| regWdata | input | 32 | Register value to be stored |
| loadResult | output | 32 | Aligned value for the register file |
| busWdata | output | 32 | Word driven onto the bus |
| byteEn | output | 4 | Per-lane write enables |

## Verification
The assertions check several properties on every cycle: zero-fill of byte loads, lane replication and pass-through on stores, the shape of the lane enables, the identity result for aligned word loads, and the one-cycle delay of the output register. Lane selection, the exact rotation amount for each offset and endianness, and the switching of endianness from one access to the next can only be shown by the bench. It sweeps every combination of endianness, size, offset and store flag with random and fixed data and compares each case against explicit rotate expressions.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = 4;
  localparam int WORD_W    = LANE_W * NUM_LANES;
  localparam int OFF_W     = $clog2(NUM_LANES);

  typedef struct packed {
    logic [OFF_W-1:0]     rotSel;   // rotate right by rotSel lanes
    logic                 maskByte; // keep only lane 0 of the rotated word
    logic                 repByte;  // replicate low byte on store
    logic [NUM_LANES-1:0] laneEn;   // write enables
  } steerCtl_t;
endpackage

// File: rtl/lane_align_ctrl.sv
module lane_align_ctrl
  import lane_align_pkg::*;
(
  input  logic             accByte,
  input  logic [OFF_W-1:0] addrLo,
  input  logic             bigEndian,
  input  logic             storeEn,
  output steerCtl_t        ctl
);
  logic [OFF_W-1:0] laneIdx;

  // Physical lane holding the addressed byte
  assign laneIdx = bigEndian ? OFF_W'(NUM_LANES - 1) - addrLo : addrLo;

  always_comb begin
    ctl          = '0;
    ctl.maskByte = accByte;
    ctl.repByte  = accByte;
    // A byte load brings the addressed lane to lane 0; a word load
    // rotates right by the offset in both orders.
    ctl.rotSel   = accByte ? laneIdx : addrLo;
    if (storeEn) begin
      if (accByte) ctl.laneEn[laneIdx] = 1'b1;
      else         ctl.laneEn = '1;
    end
  end
endmodule

// File: rtl/lane_align_dp.sv
module lane_align_dp
  import lane_align_pkg::*;
(
  input  steerCtl_t            ctl,
  input  logic [WORD_W-1:0]    busRdata,
  input  logic [WORD_W-1:0]    regWdata,
  output logic [WORD_W-1:0]    loadNext,
  output logic [WORD_W-1:0]    wdataNext,
  output logic [NUM_LANES-1:0] enNext
);
  logic [WORD_W-1:0] rotWord;

  always_comb begin
    rotWord = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      rotWord[i*LANE_W +: LANE_W] =
        busRdata[((i + int'(ctl.rotSel)) % NUM_LANES)*LANE_W +: LANE_W];
    end
  end

  assign loadNext = ctl.maskByte ? {{(WORD_W-LANE_W){1'b0}}, rotWord[LANE_W-1:0]}
                                 : rotWord;

  genvar g;
  generate
    for (g = 0; g < NUM_LANES; g++) begin : gLane
      assign wdataNext[g*LANE_W +: LANE_W] =
        ctl.repByte ? regWdata[LANE_W-1:0] : regWdata[g*LANE_W +: LANE_W];
    end
  endgenerate

  assign enNext = ctl.laneEn;
endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit
  import lane_align_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accByte,
  input  logic [OFF_W-1:0]     addrLo,
  input  logic                 bigEndian,
  input  logic                 storeEn,
  input  logic [WORD_W-1:0]    busRdata,
  input  logic [WORD_W-1:0]    regWdata,
  output logic [WORD_W-1:0]    loadResult,
  output logic [WORD_W-1:0]    busWdata,
  output logic [NUM_LANES-1:0] byteEn
);
  steerCtl_t             ctl;
  logic [WORD_W-1:0]     loadNext;
  logic [WORD_W-1:0]     wdataNext;
  logic [NUM_LANES-1:0]  enNext;

  lane_align_ctrl i_ctrl (
    .accByte(accByte), .addrLo(addrLo), .bigEndian(bigEndian),
    .storeEn(storeEn), .ctl(ctl)
  );

  lane_align_dp i_dp (
    .ctl(ctl), .busRdata(busRdata), .regWdata(regWdata),
    .loadNext(loadNext), .wdataNext(wdataNext), .enNext(enNext)
  );

  generate
    if (REG_OUT) begin : gReg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          loadResult <= '0;
          busWdata   <= '0;
          byteEn     <= '0;
        end else begin
          loadResult <= loadNext;
          busWdata   <= wdataNext;
          byteEn     <= enNext;
        end
      end

      AST_REG_DELAY: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> loadResult == $past(loadNext) && byteEn == $past(enNext)
                        && busWdata == $past(wdataNext)); // R10
    end else begin : gComb
      assign loadResult = loadNext;
      assign busWdata   = wdataNext;
      assign byteEn     = enNext;
    end
  endgenerate

  AST_BYTE_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    accByte |-> loadNext[WORD_W-1:LANE_W] == '0); // R3

  AST_BYTE_REPLICATE: assert property (@(posedge clk) disable iff (!rstN)
    accByte |-> wdataNext == {NUM_LANES{regWdata[LANE_W-1:0]}}); // R7

  AST_WORD_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !accByte |-> wdataNext == regWdata); // R8

  AST_ALIGNED_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (!accByte && addrLo == '0) |-> loadNext == busRdata); // R4

  AST_EN_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (storeEn && accByte) |-> $countones(enNext) == 1); // R9

  AST_EN_ALL_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (storeEn && !accByte) |-> enNext == '1); // R9

  AST_EN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !storeEn |-> enNext == '0); // R9
endmodule

// File: tb/test_lane_align_unit.sv
`timescale 1ns/1ps
module test_lane_align_unit;
  logic        clk = 1'b0;
  logic        rstN;
  logic        accByte, bigEndian, storeEn;
  logic [1:0]  addrLo;
  logic [31:0] busRdata, regWdata;
  logic [31:0] loadResult, busWdata;
  logic [3:0]  byteEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lane_align_unit i_lane_align_unit (
    .clk(clk), .rstN(rstN), .accByte(accByte), .addrLo(addrLo),
    .bigEndian(bigEndian), .storeEn(storeEn), .busRdata(busRdata),
    .regWdata(regWdata), .loadResult(loadResult), .busWdata(busWdata),
    .byteEn(byteEn)
  );

  function automatic logic [31:0] rotr(input logic [31:0] w, input int n);
    int s = n % 32;
    if (s == 0) return w;
    return (w >> s) | (w << (32 - s));
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One access: drive at negedge, outputs register at next posedge, sample after.
  task automatic access(input bit be, input bit isByte, input bit st,
                        input int off, input logic [31:0] rd,
                        input logic [31:0] wd);
    logic [31:0] expLoad, expWd;
    logic [3:0]  expEn;
    string       reqL;
    int          lane;
    @(negedge clk);
    bigEndian = be; accByte = isByte; storeEn = st;
    addrLo = 2'(off); busRdata = rd; regWdata = wd;
    lane = be ? 3 - off : off;
    if (isByte) begin
      expLoad = {24'h0, rd[8*lane +: 8]};
      expWd   = {4{wd[7:0]}};
      expEn   = st ? 4'(1 << lane) : 4'h0;
      reqL    = be ? "R1" : "R2";
    end else begin
      expWd   = wd;
      expEn   = st ? 4'hF : 4'h0;
      if (be) begin
        case (off)
          0: expLoad = rd;
          2: expLoad = {rd[15:0], rd[31:16]};
          1: expLoad = {rd[7:0], rd[31:8]};
          default: expLoad = {rd[23:0], rd[31:24]};
        endcase
        reqL = (off % 2 == 0) ? "R4" : "R5";
      end else begin
        expLoad = rotr(rd, 8 * off);
        reqL    = "R6";
      end
    end
    @(posedge clk);
    #1;
    check(reqL, "loadResult", loadResult, expLoad);
    if (isByte) check("R3", "upper zero", {8'h0, loadResult[31:8]}, 32'h0);
    check(isByte ? "R7" : "R8", "busWdata", busWdata, expWd);
    check("R9", "byteEn", {28'h0, byteEn}, {28'h0, expEn});
  endtask

  initial begin
    rstN = 1'b0; accByte = 0; bigEndian = 0; storeEn = 0; addrLo = 0;
    busRdata = 32'hDEADBEEF; regWdata = 32'h12345678;
    repeat (3) @(posedge clk);
    #1;
    check("R10", "reset loadResult", loadResult, 32'h0);
    check("R10", "reset busWdata", busWdata, 32'h0);
    check("R10", "reset byteEn", {28'h0, byteEn}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // Fixed pattern, full sweep
    for (int be = 0; be < 2; be++)
      for (int sz = 0; sz < 2; sz++)
        for (int st = 0; st < 2; st++)
          for (int off = 0; off < 4; off++)
            access(be[0], sz[0], st[0], off, 32'hAABBCCDD, 32'h11223344);

    // Random data, full sweep, several rounds
    for (int rep = 0; rep < 6; rep++)
      for (int be = 0; be < 2; be++)
        for (int sz = 0; sz < 2; sz++)
          for (int st = 0; st < 2; st++)
            for (int off = 0; off < 4; off++)
              access(be[0], sz[0], st[0], off, $urandom, $urandom);

    // R10: endianness flipping on every consecutive access
    for (int k = 0; k < 16; k++)
      access(k[0], k[1], 1'b1, k % 4, $urandom, $urandom);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule